// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block produces a stream of synthetic Ethernet frames for link bring-up and loopback testing. Each byte leaves on a registered valid/data/last interface, one byte per clock, at gigabit byte rate. Every frame has the same layout. It starts with a six-byte destination address and a six-byte source address. Next comes a two-byte length/type field that holds the payload byte count, then the payload. The frame ends with a four-byte CRC-32 frame check sequence. The preamble and the start-of-frame delimiter are not produced.

A handful of small configuration inputs control the frames: a two-bit size code, a gap select, a four-bit nibble for each address, a payload mode (fixed 16-bit pattern or LFSR sequence), a bad-FCS switch and a continuous/bounded switch. The generator samples these inputs once, when it starts, and uses only that copy for the whole run. A start is a rising edge of `enable`. To apply new settings, drop `enable` and raise it again.

In bounded mode the generator stops after a fixed number of frames from the start. The default is 10,000. Dropping `enable` lets the frame in flight finish and then stops the generator.

Top module: `eth_test_frame_gen`

## Requirements
- R1: The size code selects the total frame length including FCS: 2'b00 gives 125 bytes, 2'b01 gives 64, 2'b10 gives 1518 and 2'b11 gives 10,000. `out_last` is high only on the final byte.
- R2: Bytes 0..5 are FF FF FF FF FF followed by {4'hF, dst_nib}. Bytes 6..11 are FF FF FF FF FF followed by {4'hF, src_nib}.
- R3: Bytes 12 and 13 carry the payload length (frame length minus 18), most significant byte first.
- R4: With `rand_payload`=0, payload byte k (counted from byte 14) is pattern[15:8] when k is even and pattern[7:0] when k is odd.
- R5: With `rand_payload`=1, a 16-bit register s is loaded with 16'hACE1 at each start. Each payload byte is s[7:0], after which s becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}. The sequence carries on across the frames of one run.
- R6: With `bad_fcs`=0, the last four bytes are the complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) computed over bytes 0 to length-5. These bytes are sent least significant byte first.
- R7: With `bad_fcs`=1, the last four bytes are the bitwise inverse of the correct FCS.
- R8: Between consecutive frames of a run, `out_valid` is low for exactly 12 cycles when `gap_long`=0 and for exactly 1024 cycles when `gap_long`=1.
- R9: With `cont_mode`=0, exactly BOUND frames (default 10,000) are sent after a start. After that no frame is sent while `enable` stays high.
- R10: With `cont_mode`=1, frames continue past BOUND for as long as `enable` stays high.
- R11: Configuration inputs that change during a run have no effect on that run. The next start, made by dropping and raising `enable`, uses the new values.
- R12: After reset `out_valid` is low. When `enable` falls, the frame in progress completes at full length and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; a rising edge starts a run |
| cont_mode | input | 1 | 1: endless run, 0: stop after BOUND frames |
| len_code | input | 2 | Frame size select |
| gap_long | input | 1 | Gap select: 0 short, 1 long |
| dst_nib | input | 4 | Low nibble of destination address |
| src_nib | input | 4 | Low nibble of source address |
| rand_payload | input | 1 | 1: LFSR payload, 0: fixed pattern |
| bad_fcs | input | 1 | 1: corrupt FCS |
| pattern | input | 16 | Fixed payload pattern |
| out_valid | output | 1 | Byte valid |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of frame |

## Verification
The assertions assume that `enable` is a plain level that the bench drives from reset onward. They also assume that nothing but a fall of `enable` followed by a new rising edge can restart a run. The quiet-after-disable property therefore depends on `enable` having been low for two cycles. The stimulus changes configuration and `enable` only on falling clock edges. It drops `enable` either between runs or right after a frame's first byte, so each run's frames can be matched against one latched configuration. The bench reduces the frame bound to 3 so that bounded stops and the continuation past the bound fit in a short run.

// File: rtl/eth_tg_pkg.sv
package eth_tg_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} tg_state_e;

  typedef struct packed {
    logic [1:0]  len_code;
    logic        gap_long;
    logic [3:0]  dst_nib;
    logic [3:0]  src_nib;
    logic        rand_pl;
    logic        bad;
    logic        cont;
    logic [15:0] pattern;
  } tg_cfg_t;

  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/tg_sequencer.sv
module tg_sequencer
  import eth_tg_pkg::*;
#(
  parameter int LEN_C0    = 125,
  parameter int LEN_C1    = 64,
  parameter int LEN_C2    = 1518,
  parameter int LEN_C3    = 10000,
  parameter int GAP_SHORT = 12,
  parameter int GAP_LONG  = 1024,
  parameter int BOUND     = 10000,
  parameter int IW        = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  tg_cfg_t       cfg_in,
  output tg_cfg_t       cfg,
  output logic          emit,
  output logic          start,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] frame_len
);
  localparam int GW = $clog2(GAP_LONG + 1);
  localparam int PW = $clog2(BOUND + 1);

  tg_state_e     state;
  logic [GW-1:0] gap_cnt, gap_len;
  logic [PW-1:0] pkt_cnt;
  logic          en_q, arm, last_byte, halt, stop_bound;

  always_comb begin
    case (cfg.len_code)
      2'b00:   frame_len = IW'(LEN_C0);
      2'b01:   frame_len = IW'(LEN_C1);
      2'b10:   frame_len = IW'(LEN_C2);
      default: frame_len = IW'(LEN_C3);
    endcase
  end

  assign gap_len    = cfg.gap_long ? GW'(GAP_LONG) : GW'(GAP_SHORT);
  assign emit       = (state == ST_FRAME);
  assign start      = (state == ST_IDLE) && arm && enable;
  assign last_byte  = emit && (idx == frame_len - IW'(1));
  assign halt       = !enable || arm;
  assign stop_bound = !cfg.cont && (pkt_cnt == PW'(BOUND - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      gap_cnt <= '0;
      pkt_cnt <= '0;
      en_q    <= 1'b0;
      arm     <= 1'b0;
      cfg     <= '0;
    end else begin
      en_q <= enable;
      if (!enable)      arm <= 1'b0;
      else if (!en_q)   arm <= 1'b1;
      else if (start)   arm <= 1'b0;

      case (state)
        ST_IDLE: if (start) begin
          cfg     <= cfg_in;
          state   <= ST_FRAME;
          idx     <= '0;
          pkt_cnt <= '0;
        end
        ST_FRAME: if (last_byte) begin
          pkt_cnt <= (pkt_cnt == PW'(BOUND - 1)) ? '0 : pkt_cnt + PW'(1);
          if (halt || stop_bound) state <= ST_IDLE;
          else begin
            state   <= ST_GAP;
            gap_cnt <= '0;
          end
        end else begin
          idx <= idx + IW'(1);
        end
        ST_GAP: begin
          if (halt) state <= ST_IDLE;
          else if (gap_cnt == gap_len - GW'(1)) begin
            state <= ST_FRAME;
            idx   <= '0;
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state == ST_IDLE || $stable(cfg)));
  assert_pkt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    pkt_cnt < PW'(BOUND));
  assert_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
    emit |-> idx < frame_len);
  assert_gap_range_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> gap_cnt < gap_len);
endmodule

// File: rtl/tg_field_mux.sv
module tg_field_mux
  import eth_tg_pkg::*;
#(
  parameter int IW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          emit,
  input  logic [IW-1:0] idx,
  input  logic [IW-1:0] frame_len,
  input  tg_cfg_t       cfg,
  input  logic [31:0]   fcs_word,
  output logic [7:0]    byte_o,
  output logic          is_data
);
  logic [15:0]   lfsr, plen;
  logic [IW-1:0] fcs_start, pidx;
  logic [1:0]    fk;
  logic          in_payload;

  assign fcs_start  = frame_len - IW'(4);
  assign is_data    = idx < fcs_start;
  assign in_payload = is_data && (idx >= IW'(14));
  assign pidx       = idx - IW'(14);
  assign plen       = 16'(frame_len - IW'(18));
  assign fk         = 2'(idx - fcs_start);

  always_comb begin
    if (idx < IW'(5))        byte_o = 8'hFF;
    else if (idx == IW'(5))  byte_o = {4'hF, cfg.dst_nib};
    else if (idx < IW'(11))  byte_o = 8'hFF;
    else if (idx == IW'(11)) byte_o = {4'hF, cfg.src_nib};
    else if (idx == IW'(12)) byte_o = plen[15:8];
    else if (idx == IW'(13)) byte_o = plen[7:0];
    else if (is_data)        byte_o = cfg.rand_pl ? lfsr[7:0]
                                    : (pidx[0] ? cfg.pattern[7:0] : cfg.pattern[15:8]);
    else                     byte_o = fcs_word[8*fk +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || start)                          lfsr <= LFSR_SEED;
    else if (emit && in_payload && cfg.rand_pl) lfsr <= lfsr_next(lfsr);
  end

  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    lfsr != 16'h0);
endmodule

// File: rtl/tg_fcs.sv
module tg_fcs
  import eth_tg_pkg::*;
#(
  parameter int IW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          emit,
  input  logic          is_data,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    byte_in,
  input  logic          bad,
  output logic [31:0]   fcs_word
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '1;
    else if (emit && is_data)
      crc_q <= crc32_byte((idx == '0) ? 32'hFFFF_FFFF : crc_q, byte_in);
  end

  assign fcs_word = bad ? crc_q : ~crc_q;

  assert_crc_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (emit && !is_data) |=> $stable(crc_q));
endmodule

// File: rtl/eth_test_frame_gen.sv
module eth_test_frame_gen
  import eth_tg_pkg::*;
#(
  parameter int LEN_C0    = 125,
  parameter int LEN_C1    = 64,
  parameter int LEN_C2    = 1518,
  parameter int LEN_C3    = 10000,
  parameter int GAP_SHORT = 12,
  parameter int GAP_LONG  = 1024,
  parameter int BOUND     = 10000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        cont_mode,
  input  logic [1:0]  len_code,
  input  logic        gap_long,
  input  logic [3:0]  dst_nib,
  input  logic [3:0]  src_nib,
  input  logic        rand_payload,
  input  logic        bad_fcs,
  input  logic [15:0] pattern,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last
);
  localparam int IW = $clog2(LEN_C3 + 1);

  tg_cfg_t       cfg_in, cfg;
  logic          emit, start, is_data;
  logic [IW-1:0] idx, frame_len;
  logic [7:0]    byte_c;
  logic [31:0]   fcs_word;

  assign cfg_in = '{len_code: len_code, gap_long: gap_long, dst_nib: dst_nib,
                    src_nib: src_nib, rand_pl: rand_payload, bad: bad_fcs,
                    cont: cont_mode, pattern: pattern};

  tg_sequencer #(
    .LEN_C0(LEN_C0), .LEN_C1(LEN_C1), .LEN_C2(LEN_C2), .LEN_C3(LEN_C3),
    .GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG), .BOUND(BOUND), .IW(IW)
  ) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .cfg_in(cfg_in), .cfg(cfg),
    .emit(emit), .start(start), .idx(idx), .frame_len(frame_len)
  );

  tg_field_mux #(.IW(IW)) u_mux (
    .clk(clk), .rst(rst), .start(start), .emit(emit), .idx(idx),
    .frame_len(frame_len), .cfg(cfg), .fcs_word(fcs_word),
    .byte_o(byte_c), .is_data(is_data)
  );

  tg_fcs #(.IW(IW)) u_fcs (
    .clk(clk), .rst(rst), .emit(emit), .is_data(is_data), .idx(idx),
    .byte_in(byte_c), .bad(cfg.bad), .fcs_word(fcs_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= emit;
      out_data  <= emit ? byte_c : 8'h00;
      out_last  <= emit && (idx == frame_len - IW'(1));
    end
  end

  assert_last_valid_R1: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    out_last |=> !out_valid);
  assert_first_byte_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_data == 8'hFF);
  assert_quiet_off_R12: assert property (@(posedge clk) disable iff (rst)
    (!enable && !$past(enable) && !out_valid) |=> !out_valid);
endmodule

// File: tb/eth_test_frame_gen_tb.sv
module eth_test_frame_gen_tb;
  localparam int BOUND = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, cont_mode = 1'b0, gap_long = 1'b0;
  logic        rand_payload = 1'b0, bad_fcs = 1'b0;
  logic [1:0]  len_code = 2'b00;
  logic [3:0]  dst_nib = 4'h0, src_nib = 4'h0;
  logic [15:0] pattern = 16'h0;
  logic        out_valid, out_last;
  logic [7:0]  out_data;

  int tests = 0, fails = 0;
  logic [7:0]  fb [0:10015];
  logic [15:0] bl;

  always #2 clk = ~clk;

  eth_test_frame_gen #(.BOUND(BOUND)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .cont_mode(cont_mode),
    .len_code(len_code), .gap_long(gap_long), .dst_nib(dst_nib),
    .src_nib(src_nib), .rand_payload(rand_payload), .bad_fcs(bad_fcs),
    .pattern(pattern), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] c);
    case (c)
      2'b00: return 125;
      2'b01: return 64;
      2'b10: return 1518;
      default: return 10000;
    endcase
  endfunction

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic capture(input bit drop, output int len, output int idle);
    len = 0; idle = 0;
    @(negedge clk);
    while (!out_valid) begin
      idle++;
      if (idle > 40000) begin
        chk(0, "R9/R10 frame timeout", idle, 0);
        return;
      end
      @(negedge clk);
    end
    forever begin
      fb[len] = out_data;
      len++;
      if (out_last || len > 10010) break;
      @(negedge clk);
      if (drop && len == 1) enable = 1'b0;
      if (!out_valid) break;
    end
  endtask

  task automatic check_frame(input int len, input logic [1:0] lc, input logic [3:0] dn,
                             input logic [3:0] sn, input logic rnd, input logic bad,
                             input logic [15:0] pat);
    int el = len_of(lc);
    int bad_ix;
    logic [7:0]  e;
    logic [31:0] crc, fcs, got;
    chk(len == el, "R1 frame length", len, el);
    if (len != el) return;
    bad_ix = -1;
    for (int i = 0; i < 12; i++) begin
      e = (i == 5) ? {4'hF, dn} : (i == 11) ? {4'hF, sn} : 8'hFF;
      if (fb[i] != e && bad_ix < 0) bad_ix = i;
    end
    chk(bad_ix < 0, "R2 addresses", bad_ix, -1);
    chk({fb[12], fb[13]} == 16'(el - 18), "R3 length field", {fb[12], fb[13]}, el - 18);
    bad_ix = -1;
    for (int k = 0; k < el - 18; k++) begin
      if (rnd) begin e = bl[7:0]; bl = {bl[14:0], bl[15] ^ bl[13] ^ bl[12] ^ bl[10]}; end
      else e = k[0] ? pat[7:0] : pat[15:8];
      if (fb[14 + k] != e && bad_ix < 0) bad_ix = k;
    end
    if (rnd) chk(bad_ix < 0, "R5 random payload offset", bad_ix, -1);
    else     chk(bad_ix < 0, "R4 fixed payload offset", bad_ix, -1);
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < el - 4; i++) crc = crc_upd(crc, fb[i]);
    fcs = bad ? crc : ~crc;
    got = {fb[el-1], fb[el-2], fb[el-3], fb[el-4]};
    if (bad) chk(got == fcs, "R7 corrupted FCS", got, fcs);
    else     chk(got == fcs, "R6 FCS", got, fcs);
  endtask

  task automatic expect_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    #800000;
    chk(0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int len, idle;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    expect_quiet(5, "R12 idle after reset");

    // Sweep size codes and payload modes, bounded runs
    for (int code = 0; code < 4; code++) begin
      for (int r = 0; r < 2; r++) begin
        @(negedge clk);
        len_code = 2'(code); rand_payload = 1'(r); bad_fcs = 1'(r) ^ 1'(code);
        gap_long = 1'(r); cont_mode = 1'b0;
        dst_nib = {2'(code), 1'(r), ~1'(r)}; src_nib = ~dst_nib;
        pattern = 16'h1234 + 16'(code) * 16'h1111;
        enable = 1'b1;
        bl = 16'hACE1;
        for (int f = 0; f < BOUND; f++) begin
          capture(0, len, idle);
          if (f > 0) chk(idle == (r ? 1024 : 12), "R8 inter-frame gap", idle, r ? 1024 : 12);
          check_frame(len, 2'(code), dst_nib, src_nib, 1'(r), 1'(r) ^ 1'(code), pattern);
        end
        expect_quiet(1100, "R9 bounded stop");
        enable = 1'b0;
        repeat (3) @(negedge clk);
      end
    end

    // Continuous run past the bound, config change ignored mid-run
    len_code = 2'b01; rand_payload = 1'b0; bad_fcs = 1'b0; gap_long = 1'b0;
    cont_mode = 1'b1; dst_nib = 4'h3; src_nib = 4'hC; pattern = 16'hA55A;
    enable = 1'b1;
    capture(0, len, idle);
    check_frame(len, 2'b01, 4'h3, 4'hC, 1'b0, 1'b0, 16'hA55A);
    len_code = 2'b00; dst_nib = 4'h9; pattern = 16'h0F0F;
    for (int f = 1; f < BOUND + 3; f++) begin
      capture(0, len, idle);
      chk(len == 64, "R10 continuous frame present / R11 ignored change", len, 64);
      check_frame(len, 2'b01, 4'h3, 4'hC, 1'b0, 1'b0, 16'hA55A);
    end
    capture(1, len, idle);
    chk(len == 64, "R12 frame completes after disable", len, 64);
    expect_quiet(300, "R12 no frame after disable");

    // Restart picks up the new configuration
    @(negedge clk);
    enable = 1'b1;
    for (int f = 0; f < 2; f++) begin
      capture(0, len, idle);
      chk(len == 125, "R11 new size after restart", len, 125);
      check_frame(len, 2'b00, 4'h9, 4'hC, 1'b0, 1'b0, 16'h0F0F);
    end
    enable = 1'b0;
    repeat (200) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule